// File: doc/BRIEF.md
# Doorbell Interrupt Decoder

This block sits behind a serial packet receiver. Each cycle it can accept one 64-bit packet header that has already been deserialized and framed, marked by a valid strobe. Headers that carry a doorbell in 8-bit device-ID mode are decoded. Two fields of the 16-bit payload then pick a status register and a bit within it, and that bit is set. A doorbell is never tied to an earlier data transfer, so nothing outside that payload affects which bit is chosen. Any other header is dropped and produces a one-cycle discard pulse.

Software reads the flattened status registers and clears bits by writing ones to them. Each register drives its own interrupt request line, gated by an enable bit. The source ID and transaction ID of the most recently accepted doorbell are held in a capture register, so a service routine can see who rang.

Top module: `dbell_irq_decoder`

## Requirements
- R1: After synchronous reset, all status bits are 0, every irq line is low, discard is low and cap_valid is low.
- R2: A header with transport type 00 (bits [53:52]) and format type 1010 (bits [51:48]), presented with hdr_valid, sets bit info[3:0] of register info[5:4] one clock later. The payload info occupies bits [15:0].
- R3: Payload bits info[15:6] and the ackID, priority and destination ID fields have no effect on which status bit is set.
- R4: A valid header whose format type is not 1010 leaves all status bits and the capture register unchanged, and raises discard for exactly the following cycle.
- R5: A valid header whose transport type is not 00 is dropped and counted in the same way as in R4, even if its format type is 1010.
- R6: When clr_we is high, every bit of register clr_sel that is 1 in clr_mask reads 0 on the next cycle. All other bits keep their value.
- R7: When a doorbell sets a bit in the same cycle that a clear targets the same bit, the bit reads 1 afterwards.
- R8: irq[k] is high exactly while register k has at least one bit set and irq_en[k] is 1. The line follows irq_en within the same cycle.
- R9: An accepted doorbell loads source ID (bits [39:32]) into cap_src_id and transaction ID (bits [23:16]) into cap_tid on the next cycle, and sets cap_valid.
- R10: Status bits are sticky: a bit once set stays set until it is cleared, and later doorbells only add bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Header word is valid this cycle |
| hdr_data | input | 64 | Packet header, ackID in the top bits |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_sel | input | 2 | Register targeted by the clear |
| clr_mask | input | 16 | Bits to clear |
| irq_en | input | 4 | Interrupt enable, one bit per register |
| status | output | 64 | Status registers, register k at bits [16k+15:16k] |
| irq | output | 4 | Interrupt request per register |
| discard | output | 1 | One-cycle pulse for a dropped header |
| cap_valid | output | 1 | Capture register holds a doorbell |
| cap_src_id | output | 8 | Source ID of the last doorbell |
| cap_tid | output | 8 | Transaction ID of the last doorbell |

## Verification
The bench builds the block with its default parameters: four registers of sixteen bits. With these values the two payload fields span the corners that matter: bit 15 of register 3, bit 0 of register 0, and payloads whose reserved upper bits are all ones. Clears that collide with sets, headers with a wrong transport type or format type, and a stream of pseudo-random doorbells then check both the decode arithmetic and the sticky accumulation against a bench model.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    localparam int HDR_W = 64;
    localparam logic [3:0] FTYPE_DOORBELL = 4'b1010;
    localparam logic [1:0] TT_DEV8 = 2'b00;

    typedef struct packed {
        logic [4:0]  ack;
        logic [2:0]  rsv_a;
        logic [1:0]  prio;
        logic [1:0]  ttype;
        logic [3:0]  ftype;
        logic [7:0]  dest;
        logic [7:0]  src;
        logic [7:0]  rsv_b;
        logic [7:0]  tid;
        logic [15:0] info;
    } hdr_t;

    function automatic logic accept_hdr(hdr_t h);
        return (h.ttype == TT_DEV8) && (h.ftype == FTYPE_DOORBELL);
    endfunction

endpackage

// File: rtl/dbell_hdr_parse.sv
module dbell_hdr_parse
    import dbell_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        hdr_valid,
    input  logic [HDR_W-1:0]            hdr_data,
    output logic                        set_v,
    output logic [$clog2(NUM_REGS)-1:0] set_reg,
    output logic [$clog2(REG_W)-1:0]    set_bit,
    output logic [7:0]                  src_id,
    output logic [7:0]                  tid,
    output logic                        discard_q
);
    localparam int BIT_W = $clog2(REG_W);
    localparam int IDX_W = $clog2(NUM_REGS);

    hdr_t h;
    logic ok;

    always_comb begin
        h       = hdr_t'(hdr_data);
        ok      = accept_hdr(h);
        set_v   = hdr_valid && ok;
        set_bit = h.info[BIT_W-1:0];
        set_reg = h.info[BIT_W+IDX_W-1:BIT_W];
        src_id  = h.src;
        tid     = h.tid;
    end

    always_ff @(posedge clk) begin
        if (rst) discard_q <= 1'b0;
        else     discard_q <= hdr_valid && !ok;
    end

    // R4 and R5: a rejected header is followed by a discard pulse
    a_r4_discard_after_drop: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && !accept_hdr(hdr_t'(hdr_data))) |=> discard_q);
    // R2: an accepted doorbell never produces a discard pulse
    a_r2_no_discard_on_accept: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && accept_hdr(hdr_t'(hdr_data))) |=> !discard_q);

endmodule

// File: rtl/dbell_status_bank.sv
module dbell_status_bank #(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          set_v,
    input  logic [$clog2(NUM_REGS)-1:0]   set_reg,
    input  logic [$clog2(REG_W)-1:0]      set_bit,
    input  logic                          clr_we,
    input  logic [$clog2(NUM_REGS)-1:0]   clr_sel,
    input  logic [REG_W-1:0]              clr_mask,
    input  logic [NUM_REGS-1:0]           irq_en,
    output logic [NUM_REGS*REG_W-1:0]     status_flat,
    output logic [NUM_REGS-1:0]           irq
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic [NUM_REGS-1:0][REG_W-1:0] st;
    logic [NUM_REGS-1:0][REG_W-1:0] set_vec;
    logic [NUM_REGS-1:0][REG_W-1:0] clr_vec;

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        always_comb begin
            set_vec[k] = (set_v && set_reg == IDX_W'(k)) ? (REG_W'(1) << set_bit) : '0;
            clr_vec[k] = (clr_we && clr_sel == IDX_W'(k)) ? clr_mask : '0;
        end

        always_ff @(posedge clk) begin
            if (rst) st[k] <= '0;
            else     st[k] <= (st[k] & ~clr_vec[k]) | set_vec[k];
        end

        assign irq[k] = irq_en[k] && (|st[k]);
        assign status_flat[k*REG_W +: REG_W] = st[k];

        // R6: cleared bits read zero when no doorbell hits this register
        a_r6_clear_bits: assert property (@(posedge clk) disable iff (rst)
            (clr_we && clr_sel == IDX_W'(k) && !(set_v && set_reg == IDX_W'(k)))
            |=> ((st[k] & $past(clr_mask)) == '0));
        // R7: the bit set by a doorbell is present next cycle regardless of clears
        a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
            (set_v && set_reg == IDX_W'(k)) |=> st[k][$past(set_bit)]);
        // R10: without a clear no bit falls
        a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
            !clr_we |=> ((st[k] & $past(st[k])) == $past(st[k])));
    end

endmodule

// File: rtl/dbell_capture.sv
module dbell_capture (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] src_in,
    input  logic [7:0] tid_in,
    output logic       cap_valid,
    output logic [7:0] cap_src,
    output logic [7:0] cap_tid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_valid <= 1'b0;
            cap_src   <= '0;
            cap_tid   <= '0;
        end else if (load) begin
            cap_valid <= 1'b1;
            cap_src   <= src_in;
            cap_tid   <= tid_in;
        end
    end

    // R9: a loaded doorbell appears in the capture register next cycle
    a_r9_capture_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (cap_valid && cap_src == $past(src_in) && cap_tid == $past(tid_in)));
    // R9: without a load the capture holds
    a_r9_capture_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(cap_src) && $stable(cap_tid)));

endmodule

// File: rtl/dbell_irq_decoder.sv
module dbell_irq_decoder
    import dbell_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 16,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int BIT_W   = $clog2(REG_W)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      hdr_valid,
    input  logic [HDR_W-1:0]          hdr_data,
    input  logic                      clr_we,
    input  logic [IDX_W-1:0]          clr_sel,
    input  logic [REG_W-1:0]          clr_mask,
    input  logic [NUM_REGS-1:0]       irq_en,
    output logic [NUM_REGS*REG_W-1:0] status,
    output logic [NUM_REGS-1:0]       irq,
    output logic                      discard,
    output logic                      cap_valid,
    output logic [7:0]                cap_src_id,
    output logic [7:0]                cap_tid
);
    logic             set_v;
    logic [IDX_W-1:0] set_reg;
    logic [BIT_W-1:0] set_bit;
    logic [7:0]       p_src;
    logic [7:0]       p_tid;

    dbell_hdr_parse #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_parse (
        .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_data(hdr_data),
        .set_v(set_v), .set_reg(set_reg), .set_bit(set_bit),
        .src_id(p_src), .tid(p_tid), .discard_q(discard)
    );

    dbell_status_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_bank (
        .clk(clk), .rst(rst), .set_v(set_v), .set_reg(set_reg), .set_bit(set_bit),
        .clr_we(clr_we), .clr_sel(clr_sel), .clr_mask(clr_mask), .irq_en(irq_en),
        .status_flat(status), .irq(irq)
    );

    dbell_capture u_cap (
        .clk(clk), .rst(rst), .load(set_v), .src_in(p_src), .tid_in(p_tid),
        .cap_valid(cap_valid), .cap_src(cap_src_id), .cap_tid(cap_tid)
    );

    // R1: discard is a single-cycle pulse only when a header was presented
    a_r1_discard_needs_hdr: assert property (@(posedge clk) disable iff (rst)
        discard |-> $past(hdr_valid));

endmodule

// File: tb/sim_dbell_irq_decoder.sv
module sim_dbell_irq_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hdr_valid = 1'b0;
    logic [63:0] hdr_data = '0;
    logic        clr_we = 1'b0;
    logic [1:0]  clr_sel = '0;
    logic [15:0] clr_mask = '0;
    logic [3:0]  irq_en = '0;
    logic [63:0] status;
    logic [3:0]  irq;
    logic        discard;
    logic        cap_valid;
    logic [7:0]  cap_src_id;
    logic [7:0]  cap_tid;

    always #2 clk = ~clk;  // 250 MHz

    dbell_irq_decoder u0 (
        .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_data(hdr_data),
        .clr_we(clr_we), .clr_sel(clr_sel), .clr_mask(clr_mask), .irq_en(irq_en),
        .status(status), .irq(irq), .discard(discard),
        .cap_valid(cap_valid), .cap_src_id(cap_src_id), .cap_tid(cap_tid)
    );

    typedef struct {
        logic [63:0] st;
        logic [3:0]  irq;
        logic        disc;
        logic        cv;
        logic [7:0]  src;
        logic [7:0]  tid;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    logic [15:0] m_st [4];
    logic        m_cv;
    logic [7:0]  m_src, m_tid;

    function automatic logic [63:0] mk(input logic [1:0] tt, input logic [3:0] ft,
                                       input logic [7:0] src, input logic [7:0] tid,
                                       input logic [15:0] info, input logic [4:0] ack,
                                       input logic [7:0] dest);
        return {ack, 3'b000, 2'b01, tt, ft, dest, src, 8'h00, tid, info};
    endfunction

    task automatic step(input logic hv, input logic [63:0] hd, input logic cwe,
                        input logic [1:0] cs, input logic [15:0] cm,
                        input logic [3:0] en, input string tag);
        exp_t e;
        logic acc;
        @(negedge clk);
        hdr_valid = hv; hdr_data = hd; clr_we = cwe; clr_sel = cs;
        clr_mask = cm; irq_en = en;
        acc = hv && hd[53:52] == 2'b00 && hd[51:48] == 4'b1010;
        for (int k = 0; k < 4; k++) begin
            if (cwe && cs == 2'(k)) m_st[k] = m_st[k] & ~cm;
        end
        if (acc) begin
            m_st[hd[5:4]][hd[3:0]] = 1'b1;
            m_cv = 1'b1; m_src = hd[39:32]; m_tid = hd[23:16];
        end
        for (int k = 0; k < 4; k++) begin
            e.st[k*16 +: 16] = m_st[k];
            e.irq[k] = en[k] && (m_st[k] != 16'h0);
        end
        e.disc = hv && !acc;
        e.cv = m_cv; e.src = m_src; e.tid = m_tid; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input logic [3:0] en, input string tag);
        step(1'b0, 64'h0, 1'b0, 2'b00, 16'h0, en, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    // monitor: compare one expected record per clock
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (status !== e.st || irq !== e.irq || discard !== e.disc ||
                    cap_valid !== e.cv || cap_src_id !== e.src || cap_tid !== e.tid) begin
                    n_fail++;
                    $display("FAIL %s: actual st=%h irq=%b disc=%b cv=%b src=%h tid=%h expected st=%h irq=%b disc=%b cv=%b src=%h tid=%h",
                             e.tag, status, irq, discard, cap_valid, cap_src_id, cap_tid,
                             e.st, e.irq, e.disc, e.cv, e.src, e.tid);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        for (int k = 0; k < 4; k++) m_st[k] = '0;
        m_cv = 0; m_src = '0; m_tid = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        n_checks++;
        if (status !== '0 || irq !== '0 || discard !== 1'b0 || cap_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: actual st=%h irq=%b disc=%b cv=%b expected all zero",
                     status, irq, discard, cap_valid);
        end
        // R2 basic doorbells, corner bits
        step(1, mk(2'b00, 4'b1010, 8'h11, 8'h21, 16'h0000, 5'd0, 8'h01), 0, 0, 0, 4'hF, "R2 reg0 bit0");
        step(1, mk(2'b00, 4'b1010, 8'h12, 8'h22, 16'h003F, 5'd3, 8'h02), 0, 0, 0, 4'b1001, "R2/R8 reg3 bit15");
        // R3 reserved payload bits and other fields ignored
        step(1, mk(2'b00, 4'b1010, 8'h13, 8'h23, 16'hFFE5, 5'h1F, 8'hFF), 0, 0, 0, 4'hF, "R3 reg2 bit5 reserved ones");
        // R4 wrong format type
        step(1, mk(2'b00, 4'b0101, 8'hA0, 8'hB0, 16'h0011, 5'd2, 8'h03), 0, 0, 0, 4'hF, "R4 non-doorbell dropped");
        idle(4'hF, "R4 discard one cycle");
        // R5 wrong transport type
        step(1, mk(2'b01, 4'b1010, 8'hA1, 8'hB1, 16'h0012, 5'd2, 8'h03), 0, 0, 0, 4'hF, "R5 tt01 dropped");
        step(1, mk(2'b10, 4'b1010, 8'hA2, 8'hB2, 16'h0013, 5'd2, 8'h03), 0, 0, 0, 4'hF, "R5 tt10 dropped");
        idle(4'hF, "R5 idle");
        // R10 accumulate
        step(1, mk(2'b00, 4'b1010, 8'h14, 8'h24, 16'h0007, 5'd0, 8'h04), 0, 0, 0, 4'hF, "R10 reg0 bit7 add");
        step(1, mk(2'b00, 4'b1010, 8'h15, 8'h25, 16'h0030, 5'd0, 8'h04), 0, 0, 0, 4'hF, "R10 reg3 bit0 add");
        // R6 clears
        step(0, 64'h0, 1, 2'd0, 16'h0001, 4'hF, "R6 clear reg0 bit0");
        step(0, 64'h0, 1, 2'd3, 16'h8000, 4'hF, "R6 clear reg3 bit15");
        step(0, 64'h0, 1, 2'd1, 16'hFFFF, 4'hF, "R6 clear empty reg1");
        // R7 set and clear together
        step(1, mk(2'b00, 4'b1010, 8'h16, 8'h26, 16'h0007, 5'd0, 8'h05), 1, 2'd0, 16'hFFFF, 4'hF, "R7 set wins over clear");
        step(1, mk(2'b00, 4'b1010, 8'h17, 8'h27, 16'h0025, 5'd0, 8'h05), 1, 2'd2, 16'h0020, 4'hF, "R7 set wins reg2 bit5");
        // R8 enable gating
        idle(4'b0000, "R8 all disabled");
        idle(4'b0100, "R8 reg2 only");
        step(0, 64'h0, 1, 2'd2, 16'hFFFF, 4'b0100, "R8 irq falls after clear");
        idle(4'hF, "R8 reenable");
        // R9 capture held across drop
        step(1, mk(2'b00, 4'b0001, 8'hEE, 8'hDD, 16'h0001, 5'd0, 8'h06), 0, 0, 0, 4'hF, "R9 capture holds on drop");
        // pseudo-random doorbells and clears
        lfsr = 16'hACE1;
        for (int i = 0; i < 200; i++) begin
            logic [63:0] h;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            h = mk(lfsr[1:0] == 2'b11 ? 2'b01 : 2'b00,
                   lfsr[2] ? 4'b1010 : lfsr[6:3], lfsr[15:8], lfsr[7:0],
                   {lfsr[9:0], lfsr[15:10]}, lfsr[4:0], lfsr[12:5]);
            step(lfsr[14], h, lfsr[11], lfsr[3:2], {lfsr[7:0], lfsr[15:8]} & 16'h1248,
                 lfsr[13:10], "R2/R6/R9 random mix");
        end
        idle(4'hF, "final");
        idle(4'hF, "final");
        wait (exp_q.size() == 0);
        @(posedge clk);
        #1;
        finish_run();
    end

endmodule